// File: doc/BRIEF.md
# Byte-Serial AES-128 Encryption Engine

This block encrypts a single 128-bit block under a 128-bit key using an 8-bit datapath. After a `start` pulse it takes 32 bytes over a valid/ready input stream: first the 16 key bytes, then the 16 plaintext bytes. It runs the ten AES-128 rounds internally and then presents the 16 ciphertext bytes on a valid/ready output stream.

Storage is split between a 16-byte state register and a 16-byte key register. Both shift one byte per clock. A single S-box is shared in time by the key schedule and by the substitution step of each round. ShiftRows is a one-cycle permutation wired into the state register. Column mixing uses a unit built around four 8-bit registers that accepts one byte and returns one byte per clock. Each register is written only in the cycles its enable selects.

Stream rules:
- A byte moves on a rising edge where valid and ready are both high.
- `in_valid` may rise or fall at any time.
- `in_ready` is high only while the block expects key or plaintext bytes.
- Once `out_valid` is high it stays high, and `out_data` does not change, until the byte is taken with `out_ready`.

Top module: `aesb_enc`

## Requirements
- R1: After reset, `busy`, `in_ready` and `out_valid` are low.
- R2: A `start` pulse while idle makes `busy` and `in_ready` high from the next cycle. The first 16 accepted bytes are the key and the next 16 are the plaintext. Byte 0 is sent first, and byte i sits at row i mod 4, column i div 4 of the state.
- R3: `in_ready` is low whenever the block is not loading, and an `in_valid` byte offered then has no effect on the result.
- R4: The 16 output bytes equal the AES-128 encryption of the plaintext under the key. Round 0 is the key addition alone, each round key uses the next round constant in the order 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36, and the tenth round has no column mixing.
- R5: Ciphertext leaves byte 0 first. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds. `busy` falls in the cycle after the 16th output byte is taken.
- R6: `start` while `busy` is high has no effect on the sequence or the result.
- R7: When the key schedule and the state both need the S-box, the key schedule wins. The state register is held during the first 4 cycles of every round. This fixes the gap from the last plaintext byte to `out_valid` at exactly 658 clock cycles.
- R8: The key register holds its contents during column mixing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin loading a new key and block (sampled only when idle) |
| busy | output | 1 | High from start until the last ciphertext byte is taken |
| in_valid | input | 1 | Input byte is present |
| in_ready | output | 1 | Block accepts an input byte |
| in_data | input | 8 | Key byte, then plaintext byte |
| out_valid | output | 1 | Ciphertext byte is present |
| out_ready | input | 1 | Consumer takes the ciphertext byte |
| out_data | output | 8 | Ciphertext byte |

## Verification
At the start of every round, two operations want the S-box in the same cycle: the key schedule's word substitution and the state's byte substitution. This overlap happens on every encryption, so each random and directed block provokes it ten times. The outcome is judged in three ways. The ciphertext is compared with a bench reference model. The cycle count from the last plaintext byte to the first output byte must be exactly 658, which holds only if the state yields the S-box for four cycles per round. An assertion in the RTL checks that the state holds in those cycles.

// File: rtl/aesb_pkg.sv
package aesb_pkg;
  localparam int BYTE_W       = 8;
  localparam int BLK_BYTES    = 16;
  localparam int COL_BYTES    = 4;
  localparam int NUM_ROUNDS   = 10;
  localparam int KEY_SBOX_CYC = COL_BYTES;
  localparam int SUB_CYC      = BLK_BYTES + KEY_SBOX_CYC;
  localparam int MIX_CYC      = 2 * BLK_BYTES;
  localparam int CNT_W        = $clog2(MIX_CYC);
  localparam int RND_W        = $clog2(NUM_ROUNDS + 1);

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_LDKEY, PH_LDTXT, PH_SUBKEY, PH_SHROW, PH_MIX, PH_ARK, PH_OUT
  } phase_e;

  function automatic byte_t gf_x2(input byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gf_mul(input byte_t a, input byte_t b);
    byte_t r = '0;
    byte_t t = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) r = r ^ t;
      t = gf_x2(t);
    end
    return r;
  endfunction

  function automatic byte_t rotl(input byte_t x, input int n);
    return byte_t'((x << n) | (x >> (BYTE_W - n)));
  endfunction
endpackage

// File: rtl/aesb_sbox.sv
module aesb_sbox
  import aesb_pkg::*;
(
  input  byte_t sb_in,
  output byte_t sb_out
);
  byte_t inv, pw;

  // multiplicative inverse as x^254 = product of x^(2^k), k = 1..7
  always_comb begin
    inv = 8'h01;
    pw  = sb_in;
    for (int k = 1; k < BYTE_W; k++) begin
      pw  = gf_mul(pw, pw);
      inv = gf_mul(inv, pw);
    end
  end

  assign sb_out = inv ^ rotl(inv, 1) ^ rotl(inv, 2) ^ rotl(inv, 3) ^
                  rotl(inv, 4) ^ 8'h63;
endmodule

// File: rtl/aesb_mixcol.sv
module aesb_mixcol
  import aesb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  emit,
  input  byte_t din,
  output byte_t dout
);
  byte_t m_q [COL_BYTES];

  // row i output = 2*a_i ^ 3*a_(i+1) ^ a_(i+2) ^ a_(i+3); rotation steps i
  assign dout = gf_x2(m_q[0]) ^ gf_x2(m_q[1]) ^ m_q[1] ^ m_q[2] ^ m_q[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < COL_BYTES; i++) m_q[i] <= '0;
    end else if (load || emit) begin
      for (int i = 0; i < COL_BYTES - 1; i++) m_q[i] <= m_q[i+1];
      m_q[COL_BYTES-1] <= load ? din : m_q[0];
    end
  end
endmodule

// File: rtl/aesb_ctrl.sv
module aesb_ctrl
  import aesb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             in_valid,
  input  logic             out_ready,
  output phase_e           phase,
  output logic [CNT_W-1:0] cnt,
  output logic             last_round,
  output byte_t            rcon,
  output logic             in_ready,
  output logic             out_valid,
  output logic             busy,
  output logic             in_beat,
  output logic             out_beat
);
  localparam logic [CNT_W-1:0] BLK_LAST = CNT_W'(BLK_BYTES - 1);
  localparam logic [CNT_W-1:0] SUB_LAST = CNT_W'(SUB_CYC - 1);
  localparam logic [CNT_W-1:0] MIX_LAST = CNT_W'(MIX_CYC - 1);

  logic [RND_W-1:0] rnd;

  assign busy       = (phase != PH_IDLE);
  assign in_ready   = (phase == PH_LDKEY) || (phase == PH_LDTXT);
  assign out_valid  = (phase == PH_OUT);
  assign in_beat    = in_valid && in_ready;
  assign out_beat   = out_valid && out_ready;
  assign last_round = (rnd == RND_W'(NUM_ROUNDS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      rnd   <= '0;
      rcon  <= 8'h01;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_LDKEY;
          cnt   <= '0;
          rnd   <= RND_W'(1);
          rcon  <= 8'h01;
        end
        PH_LDKEY, PH_LDTXT: if (in_beat) begin
          if (cnt == BLK_LAST) begin
            phase <= (phase == PH_LDKEY) ? PH_LDTXT : PH_SUBKEY;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        PH_SUBKEY: if (cnt == SUB_LAST) begin
          phase <= PH_SHROW;
          cnt   <= '0;
          rcon  <= gf_x2(rcon);
        end else cnt <= cnt + 1'b1;
        PH_SHROW: begin
          phase <= last_round ? PH_ARK : PH_MIX;
          cnt   <= '0;
        end
        PH_MIX: if (cnt == MIX_LAST) begin
          phase <= PH_ARK;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        PH_ARK: if (cnt == BLK_LAST) begin
          cnt <= '0;
          if (last_round) phase <= PH_OUT;
          else begin
            phase <= PH_SUBKEY;
            rnd   <= rnd + 1'b1;
          end
        end else cnt <= cnt + 1'b1;
        PH_OUT: if (out_beat) begin
          if (cnt == BLK_LAST) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && start) |=> (busy && in_ready)); // R2
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && phase != PH_LDKEY) |=> (phase != PH_LDKEY)); // R6
  AST_OUT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_beat && cnt == BLK_LAST) |=> !busy); // R5
endmodule

// File: rtl/aesb_enc.sv
module aesb_enc
  import aesb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       busy,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data
);
  localparam logic [CNT_W-1:0] KS_LAST = CNT_W'(KEY_SBOX_CYC - 1);
  localparam int               TOP_COL = BLK_BYTES - COL_BYTES;

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             last_round, in_beat, out_beat;
  byte_t            rcon;

  byte_t st_q [BLK_BYTES];
  byte_t st_d [BLK_BYTES];
  byte_t key_q[BLK_BYTES];
  byte_t key_d[BLK_BYTES];
  logic  st_en, key_en;

  byte_t sb_in, sb_out, mix_out, key_feed;
  logic  key_owns_sbox, mix_load, mix_emit;

  aesb_ctrl u_ctrl (
    .clk, .rst_n, .start, .in_valid, .out_ready,
    .phase, .cnt, .last_round, .rcon,
    .in_ready, .out_valid, .busy, .in_beat, .out_beat
  );

  // shared S-box: key schedule first during the first column's worth of cycles
  assign key_owns_sbox = (phase == PH_SUBKEY) && (cnt <= KS_LAST);
  assign sb_in = key_owns_sbox ? ((cnt == KS_LAST) ? key_q[9] : key_q[13])
                               : st_q[0];

  aesb_sbox u_sbox (.sb_in(sb_in), .sb_out(sb_out));

  assign mix_load = (phase == PH_MIX) && !cnt[2];
  assign mix_emit = (phase == PH_MIX) &&  cnt[2];

  aesb_mixcol u_mix (
    .clk, .rst_n, .load(mix_load), .emit(mix_emit), .din(st_q[0]), .dout(mix_out)
  );

  assign key_feed = key_owns_sbox
                  ? (sb_out ^ ((cnt == '0) ? rcon : 8'h00))
                  : key_q[12];

  // state register next value and enable
  always_comb begin
    st_en = 1'b0;
    for (int i = 0; i < BLK_BYTES; i++) st_d[i] = st_q[i];
    unique case (phase)
      PH_LDTXT: if (in_beat) begin
        st_en = 1'b1;
        for (int i = 0; i < BLK_BYTES - 1; i++) st_d[i] = st_q[i+1];
        st_d[BLK_BYTES-1] = in_data ^ key_q[0];
      end
      PH_SUBKEY: if (!key_owns_sbox) begin
        st_en = 1'b1;
        for (int i = 0; i < BLK_BYTES - 1; i++) st_d[i] = st_q[i+1];
        st_d[BLK_BYTES-1] = sb_out;
      end
      PH_SHROW: begin
        st_en = 1'b1;
        for (int r = 0; r < COL_BYTES; r++)
          for (int c = 0; c < COL_BYTES; c++)
            st_d[r + COL_BYTES*c] = st_q[r + COL_BYTES*((c + r) % COL_BYTES)];
      end
      PH_MIX: begin
        st_en = 1'b1;
        if (mix_load) begin
          for (int i = 0; i < BLK_BYTES - 1; i++) st_d[i] = st_q[i+1];
          st_d[BLK_BYTES-1] = st_q[0];
        end else begin
          st_d[TOP_COL + int'(cnt[1:0])] = mix_out;
        end
      end
      PH_ARK: begin
        st_en = 1'b1;
        for (int i = 0; i < BLK_BYTES - 1; i++) st_d[i] = st_q[i+1];
        st_d[BLK_BYTES-1] = st_q[0] ^ key_q[0];
      end
      PH_OUT: if (out_beat) begin
        st_en = 1'b1;
        for (int i = 0; i < BLK_BYTES - 1; i++) st_d[i] = st_q[i+1];
        st_d[BLK_BYTES-1] = st_q[0];
      end
      default: st_en = 1'b0;
    endcase
  end

  // key register next value and enable
  always_comb begin
    key_en = 1'b0;
    for (int i = 0; i < BLK_BYTES; i++) key_d[i] = key_q[i];
    unique case (phase)
      PH_LDKEY, PH_LDTXT: if (in_beat) begin
        key_en = 1'b1;
        for (int i = 0; i < BLK_BYTES - 1; i++) key_d[i] = key_q[i+1];
        key_d[BLK_BYTES-1] = (phase == PH_LDKEY) ? in_data : key_q[0];
      end
      PH_SUBKEY: if (cnt < CNT_W'(BLK_BYTES)) begin
        key_en = 1'b1;
        for (int i = 0; i < BLK_BYTES - 1; i++) key_d[i] = key_q[i+1];
        key_d[BLK_BYTES-1] = key_q[0] ^ key_feed;
      end
      PH_ARK: begin
        key_en = 1'b1;
        for (int i = 0; i < BLK_BYTES - 1; i++) key_d[i] = key_q[i+1];
        key_d[BLK_BYTES-1] = key_q[0];
      end
      default: key_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BLK_BYTES; i++) st_q[i] <= '0;
    end else if (st_en) begin
      for (int i = 0; i < BLK_BYTES; i++) st_q[i] <= st_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BLK_BYTES; i++) key_q[i] <= '0;
    end else if (key_en) begin
      for (int i = 0; i < BLK_BYTES; i++) key_q[i] <= key_d[i];
    end
  end

  assign out_data = st_q[0];

  AST_SBOX_KEY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    key_owns_sbox |=> ($stable(st_q[0]) && $stable(st_q[BLK_BYTES-1]))); // R7
  AST_KEY_HELD_MIX: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_MIX) |=> ($stable(key_q[0]) && $stable(key_q[12]))); // R8
  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data)); // R5
  AST_IDLE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !in_ready); // R3
endmodule

// File: tb/sim_aesb_enc.sv
module sim_aesb_enc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       out_ready = 1'b0;
  logic       busy, in_ready, out_valid;
  logic [7:0] out_data;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;
  logic [7:0] sb [256];

  always #2 clk = ~clk;

  aesb_enc u0 (
    .clk, .rst_n, .start, .busy, .in_valid, .in_ready, .in_data,
    .out_valid, .out_ready, .out_data
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] bxt(input logic [7:0] a);
    return (a << 1) ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 0;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= a;
      a = bxt(a);
    end
    return r;
  endfunction

  task automatic build_sbox();
    for (int a = 0; a < 256; a++) begin
      logic [7:0] inv = 0, y;
      for (int b = 1; b < 256; b++)
        if (bmul(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
      for (int i = 0; i < 8; i++)
        y[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^
               inv[(i+7)%8] ^ ((8'h63 >> i) & 1'b1);
      sb[a] = y;
    end
  endtask

  function automatic logic [127:0] ref_enc(input logic [127:0] k, input logic [127:0] p);
    logic [7:0] s[16], t[16], w[16], g[4], rc;
    logic [127:0] res;
    for (int i = 0; i < 16; i++) begin
      w[i] = k[127-8*i -: 8];
      s[i] = p[127-8*i -: 8] ^ w[i];
    end
    rc = 8'h01;
    for (int r = 1; r <= 10; r++) begin
      for (int i = 0; i < 16; i++) s[i] = sb[s[i]];
      for (int row = 0; row < 4; row++)
        for (int c = 0; c < 4; c++) t[row+4*c] = s[row+4*((c+row)%4)];
      for (int c = 0; c < 4; c++)
        for (int i = 0; i < 4; i++)
          s[4*c+i] = (r == 10) ? t[4*c+i] :
                     bxt(t[4*c+i]) ^ bmul(t[4*c+(i+1)%4], 8'h03) ^
                     t[4*c+(i+2)%4] ^ t[4*c+(i+3)%4];
      g[0] = sb[w[13]] ^ rc; g[1] = sb[w[14]]; g[2] = sb[w[15]]; g[3] = sb[w[12]];
      for (int i = 0; i < 4; i++) w[i] ^= g[i];
      for (int i = 4; i < 16; i++) w[i] ^= w[i-4];
      rc = bxt(rc);
      for (int i = 0; i < 16; i++) s[i] ^= w[i];
    end
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
    return res;
  endfunction

  task automatic send_byte(input logic [7:0] d, input bit gaps);
    bit ok;
    if (gaps) repeat ($urandom % 3) begin
      in_valid = 0;
      @(posedge clk); #1;
    end
    in_valid = 1; in_data = d;
    forever begin
      ok = in_ready;
      @(posedge clk); #1;
      if (ok) break;
    end
    in_valid = 0;
  endtask

  task automatic run_enc(input logic [127:0] k, input logic [127:0] p,
                         input bit gaps, input bit poke, input string tag);
    logic [127:0] got, exp;
    int n;
    exp = ref_enc(k, p);
    start = 1;
    @(posedge clk); #1;
    start = 0;
    chk(busy && in_ready, "R2", {tag, " busy/in_ready after start"},
        {126'd0, busy, in_ready}, 128'd3);
    for (int i = 0; i < 16; i++) send_byte(k[127-8*i -: 8], gaps);
    for (int i = 0; i < 16; i++) begin
      if (poke && i == 5) start = 1;      // R6: start during load
      send_byte(p[127-8*i -: 8], gaps);
      start = 0;
    end
    n = 0;
    while (!out_valid && n < 2000) begin
      in_valid = gaps ? 1'($urandom % 2) : 1'b0;   // R3: offered while not ready
      in_data = 8'($urandom);
      if (poke && n == 100) start = 1;              // R6: start while computing
      @(posedge clk); #1;
      start = 0;
      n++;
    end
    in_valid = 0;
    chk(n == 658, "R7", {tag, " latency"}, 128'(n), 128'd658);
    for (int i = 0; i < 16; i++) begin
      bit ok;
      logic [7:0] d;
      if (gaps) begin
        int st = $urandom % 3;
        out_ready = 0;
        repeat (st) begin
          logic [7:0] hold = out_data;
          @(posedge clk); #1;
          chk(out_valid && out_data == hold, "R5", {tag, " stall hold"},
              {119'd0, out_valid, out_data}, {119'd1, 1'b1 ? hold : 8'h0});
        end
      end
      out_ready = 1;
      forever begin
        ok = out_valid; d = out_data;
        @(posedge clk); #1;
        if (ok) break;
      end
      got[127-8*i -: 8] = d;
    end
    out_ready = 0;
    chk(got == exp, "R4", {tag, " ciphertext"}, got, exp);
    chk(!busy && !out_valid, "R5", {tag, " idle after last byte"},
        {126'd0, busy, out_valid}, 128'd0);
  endtask

  initial begin
    logic [127:0] fk, fp, fc;
    void'($urandom(32'd20240517));
    build_sbox();
    fk = 128'h000102030405060708090a0b0c0d0e0f;
    fp = 128'h00112233445566778899aabbccddeeff;
    fc = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    repeat (5) @(posedge clk);
    #1;
    chk(!busy && !in_ready && !out_valid, "R1", "reset outputs",
        {125'd0, busy, in_ready, out_valid}, 128'd0);
    rst_n = 1;
    @(posedge clk); #1;
    // R3: junk offered while idle
    in_valid = 1; in_data = 8'hA5;
    repeat (3) begin
      @(posedge clk); #1;
      chk(!in_ready && !busy, "R3", "idle in_ready", {126'd0, in_ready, busy}, 128'd0);
    end
    in_valid = 0;
    chk(ref_enc(fk, fp) == fc, "R4", "bench model known answer", ref_enc(fk, fp), fc);
    run_enc(fk, fp, 1'b0, 1'b0, "known-answer");
    run_enc(128'd0, 128'd0, 1'b1, 1'b0, "all-zero");
    run_enc({128{1'b1}}, {128{1'b1}}, 1'b1, 1'b0, "all-ones");
    run_enc(fk, fp, 1'b1, 1'b1, "start-poke");
    for (int v = 0; v < 6; v++) begin
      logic [127:0] rk, rp;
      rk = {$urandom, $urandom, $urandom, $urandom};
      rp = {$urandom, $urandom, $urandom, $urandom};
      run_enc(rk, rp, 1'b1, v[0], "random");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule